// File: doc/BRIEF.md
# AES Round-Key Schedule Writer

This block expands a cipher key of 128, 192 or 256 bits into the complete forward AES key schedule. A one-cycle start pulse captures a 256-bit key bus and a 2-bit length code. The block then derives one 32-bit schedule word per clock. Each pair of words leaves the block as one 64-bit write to an external pair of 16-entry by 64-bit memories. The low bit of the write address selects which of the two memories takes the write. The upper address bits give the round-key index.

The write port is a plain strobe with address and data and has no back-pressure. The memories are assumed to accept a write on every cycle that the strobe is high. A decryption datapath reads the same entries in reverse round order and applies its own inverse column mixing. When the whole schedule has been written, a ready flag rises and stays high until the next start pulse.

Top module: `aes_key_sched`

## Requirements
- R1: During and after reset, with no start pulse given, `sched_ready` and `mem_wr` are both 0.
- R2: The length code `key_mode` is sampled with `start`. Code 0 selects 128 bits and 10 rounds, code 1 selects 192 bits and 12 rounds, and code 2 selects 256 bits and 14 rounds. The block writes round keys 0 through the round count, which is 22, 26 or 30 writes.
- R3: Writes appear one per cycle at most, in strictly increasing address order starting at address 0. Address bits 4:1 hold the round-key index. Address bit 0 set to 0 carries round-key bits 127:64, and set to 1 it carries bits 63:0.
- R4: For 128-bit keys the written values match the standard forward schedule. The last round key for key 2b7e151628aed2a6abf7158809cf4f3c is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R5: For 192-bit keys the written values match the standard forward schedule, with round constants starting at 0x01 and doubling in GF(2^8), so that 0x1B follows 0x80.
- R6: For 256-bit keys the written values match the standard schedule. This includes a byte substitution without rotation at word indices i where i mod 8 equals 4.
- R7: For 128- and 192-bit keys the key is taken from the most significant bits of `key`. The unused low bits have no effect on any written value.
- R8: `sched_ready` is 0 in the cycle after a start pulse. It becomes 1 in the cycle after the final write and stays 1, with no further writes, until the next start.
- R9: A start pulse during an expansion abandons it. The new schedule is written from address 0 with the new key and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that captures key and length and begins expansion |
| key_mode | input | 2 | Key length code: 0 = 128, 1 = 192, 2 = 256 bits |
| key | input | 256 | Cipher key, left-aligned for shorter lengths |
| mem_wr | output | 1 | Write strobe to the round-key memories |
| mem_addr | output | 5 | Bits 4:1 round-key index, bit 0 half select |
| mem_wdata | output | 64 | One half of a round key |
| sched_ready | output | 1 | Whole schedule written |

## Verification
On every cycle the assertions check four things. Addresses advance by exactly one from zero with no gaps. No address passes the last one for the selected length. The ready flag only rises right after the final write and is never high with a write strobe. Start always clears ready. Whether the written words are correct can only be shown by the bench scenarios. These compare published vectors for all three lengths and random keys against a model, vary the ignored key bits, and restart the block in the middle of a schedule.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

  typedef logic [7:0] gf_byte_t;

  function automatic gf_byte_t gf_xtime(input gf_byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic gf_byte_t gf_mul(input gf_byte_t a, input gf_byte_t b);
    gf_byte_t acc;
    gf_byte_t sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, zero maps to zero
  function automatic gf_byte_t gf_inv(input gf_byte_t x);
    gf_byte_t sq;
    gf_byte_t res;
    sq  = x;
    res = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      res = gf_mul(res, sq);
    end
    return res;
  endfunction

  function automatic gf_byte_t sub_byte(input gf_byte_t x);
    gf_byte_t b;
    b = gf_inv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  // words held by the key: 4, 6 or 8
  function automatic logic [3:0] words_of(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] rounds_of(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd10;
      2'd1:    return 4'd12;
      default: return 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/aes_kx_sbox.sv
module aes_kx_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  assign dout = aes_kx_pkg::sub_byte(din);
endmodule

// File: rtl/aes_kx_next_word.sv
module aes_kx_next_word #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] prev_word,
  input  logic [WORD_W-1:0] back_word,
  input  logic [7:0]        rcon,
  input  logic              rot_sub,
  input  logic              sub_only,
  output logic [WORD_W-1:0] next_word
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] sub_word;
  logic [WORD_W-1:0] temp_word;

  assign sel_word = rot_sub ? {prev_word[WORD_W-9:0], prev_word[WORD_W-1 -: 8]}
                            : prev_word;

  for (genvar g = 0; g < NBYTES; g++) begin : g_sbox
    aes_kx_sbox u_sb (
      .din  (sel_word[g*8 +: 8]),
      .dout (sub_word[g*8 +: 8])
    );
  end

  always_comb begin
    if (rot_sub)       temp_word = sub_word ^ {rcon, {(WORD_W-8){1'b0}}};
    else if (sub_only) temp_word = sub_word;
    else               temp_word = prev_word;
    next_word = back_word ^ temp_word;
  end
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched #(
  parameter int KEY_W  = 256,
  parameter int HALF_W = 64,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        key_mode,
  input  logic [KEY_W-1:0]  key,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [HALF_W-1:0] mem_wdata,
  output logic              sched_ready
);
  import aes_kx_pkg::*;

  localparam int WORD_W = HALF_W / 2;
  localparam int HIST_N = KEY_W / WORD_W;
  localparam int IDX_W  = ADDR_W + 1;

  logic [KEY_W-1:0]  key_q;
  logic [1:0]        mode_q;
  logic              busy;
  logic [IDX_W-1:0]  widx;
  logic [2:0]        phase;
  logic [7:0]        rcon_q;
  logic [WORD_W-1:0] hist [HIST_N];
  logic [WORD_W-1:0] hi_q;

  logic [3:0]        nk, nr;
  logic [IDX_W-1:0]  nk_ext, last_word;
  logic [ADDR_W-1:0] last_addr;
  logic              in_key;
  logic [WORD_W-1:0] key_word, back_word, step_word, new_word;
  logic              rot_sub, sub_only;

  assign nk        = words_of(mode_q);
  assign nr        = rounds_of(mode_q);
  assign nk_ext    = IDX_W'(nk);
  assign last_word = IDX_W'({nr, 2'b11});
  assign last_addr = ADDR_W'({nr, 1'b1});
  assign in_key    = widx < nk_ext;

  always_comb begin
    key_word  = '0;
    back_word = '0;
    for (int k = 0; k < HIST_N; k++) begin
      if (widx == IDX_W'(k))        key_word  = key_q[(HIST_N-1-k)*WORD_W +: WORD_W];
      if (HIST_N - k == int'(nk))   back_word = hist[k];
    end
  end

  assign rot_sub  = !in_key && (phase == 3'd0);
  assign sub_only = !in_key && (nk == 4'd8) && (phase == 3'd4);

  aes_kx_next_word #(.WORD_W(WORD_W)) u_step (
    .prev_word (hist[HIST_N-1]),
    .back_word (back_word),
    .rcon      (rcon_q),
    .rot_sub   (rot_sub),
    .sub_only  (sub_only),
    .next_word (step_word)
  );

  assign new_word = in_key ? key_word : step_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q       <= '0;
      mode_q      <= '0;
      busy        <= 1'b0;
      widx        <= '0;
      phase       <= '0;
      rcon_q      <= 8'h01;
      hi_q        <= '0;
      mem_wr      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      sched_ready <= 1'b0;
      for (int k = 0; k < HIST_N; k++) hist[k] <= '0;
    end else if (start) begin
      key_q       <= key;
      mode_q      <= key_mode;
      busy        <= 1'b1;
      widx        <= '0;
      phase       <= '0;
      rcon_q      <= 8'h01;
      mem_wr      <= 1'b0;
      sched_ready <= 1'b0;
    end else if (busy) begin
      for (int k = 0; k < HIST_N-1; k++) hist[k] <= hist[k+1];
      hist[HIST_N-1] <= new_word;
      if (!widx[0]) begin
        hi_q   <= new_word;
        mem_wr <= 1'b0;
      end else begin
        mem_wr    <= 1'b1;
        mem_addr  <= widx[IDX_W-1:1];
        mem_wdata <= {hi_q, new_word};
      end
      phase <= (phase == 3'(nk - 4'd1)) ? 3'd0 : phase + 3'd1;
      if (rot_sub) rcon_q <= gf_xtime(rcon_q);
      widx <= widx + 1'b1;
      if (widx == last_word) busy <= 1'b0;
    end else begin
      mem_wr <= 1'b0;
      if (mem_wr && mem_addr == last_addr) sched_ready <= 1'b1;
    end
  end

  // checker state: next address the write port should carry
  logic [ADDR_W-1:0] chk_next_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_next_addr <= '0;
    else if (start)  chk_next_addr <= '0;
    else if (mem_wr) chk_next_addr <= mem_addr + 1'b1;
  end

  // R3
  addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == chk_next_addr);

  // R2
  addr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr <= last_addr);

  // R8
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sched_ready) |-> $past(mem_wr) && $past(mem_addr) == last_addr);

  // R8
  ready_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_ready |-> !mem_wr);

  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sched_ready);

endmodule

// File: tb/aes_key_sched_test.sv
module aes_key_sched_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   key_mode;
  logic [255:0] key;
  logic         mem_wr;
  logic [4:0]   mem_addr;
  logic [63:0]  mem_wdata;
  logic         sched_ready;

  always #5 clk = ~clk;

  aes_key_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_mode(key_mode), .key(key),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sched_ready(sched_ready)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0]  sbt [256];
  logic [63:0] cap [32];
  logic [63:0] exp_h [32];
  int          ncap;
  bit          order_ok;
  bit          timing_ok;
  bit          ready_low_ok;
  bit          done_flag = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4);
      sbt[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sbt[0] = 8'h63;
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
  endfunction

  function automatic int nk_m(input logic [1:0] m);
    return (m == 0) ? 4 : (m == 1) ? 6 : 8;
  endfunction

  function automatic int nhalves(input logic [1:0] m);
    return 2 * ((m == 0) ? 11 : (m == 1) ? 13 : 15);
  endfunction

  task automatic model(input logic [255:0] k, input logic [1:0] m);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc;
    int nk, nw;
    nk = nk_m(m);
    nw = 2 * nhalves(m);
    rc = 8'h01;
    for (int i = 0; i < nw; i++) begin
      if (i < nk) w[i] = k[255 - 32*i -: 32];
      else begin
        t = w[i-1];
        if (i % nk == 0) begin
          t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
          rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
        end else if (nk == 8 && i % 8 == 4) t = subw(t);
        w[i] = w[i-nk] ^ t;
      end
    end
    for (int j = 0; j < nw / 2; j++) exp_h[j] = {w[2*j], w[2*j+1]};
  endtask

  task automatic pulse_start(input logic [255:0] k, input logic [1:0] m);
    @(negedge clk);
    start = 1'b1; key = k; key_mode = m;
    @(negedge clk);
    start = 1'b0; key = {8{$urandom}};
  endtask

  task automatic run(input logic [255:0] k, input logic [1:0] m);
    int last_cyc, cyc;
    pulse_start(k, m);
    ready_low_ok = (sched_ready == 1'b0);
    ncap = 0; order_ok = 1; timing_ok = 0; last_cyc = -10;
    for (cyc = 0; cyc < 400; cyc++) begin
      if (mem_wr) begin
        if (ncap > 31 || mem_addr != 5'(ncap)) order_ok = 0;
        if (ncap < 32) cap[ncap] = mem_wdata;
        ncap++;
        last_cyc = cyc;
      end
      if (sched_ready) begin
        timing_ok = (cyc == last_cyc + 1);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_run(input string req, input logic [1:0] m);
    bit vals_ok;
    int bad;
    check(ready_low_ok, "R8", "ready low after start", 0, 0);
    check(ncap == nhalves(m), "R2", "write count", ncap, nhalves(m));
    check(order_ok, "R3", "address order", 0, 1);
    check(timing_ok, "R8", "ready one cycle after last write", 0, 1);
    vals_ok = 1; bad = 0;
    for (int j = 0; j < nhalves(m) && j < ncap; j++)
      if (cap[j] !== exp_h[j]) begin vals_ok = 0; bad = j; end
    check(vals_ok, req, "schedule values", cap[bad], exp_h[bad]);
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] k128, k192, k256, kr;
    void'($urandom(32'h5eed_2024));
    build_sbox();
    rst_n = 1'b0; start = 1'b0; key = '0; key_mode = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sched_ready == 0 && mem_wr == 0, "R1", "reset outputs", {sched_ready, mem_wr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sched_ready == 0 && mem_wr == 0, "R1", "idle after reset", {sched_ready, mem_wr}, 0);

    // R4 published 128-bit vector
    k128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    model(k128, 2'd0); run(k128, 2'd0); check_run("R4", 2'd0);
    check({cap[20], cap[21]} == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4",
          "last round key", {cap[20], cap[21]}, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    check(cap[0] == 64'h2b7e151628aed2a6, "R3", "round 0 upper half at addr 0",
          cap[0], 64'h2b7e151628aed2a6);
    // R8 ready holds, no writes while idle
    repeat (5) begin
      @(negedge clk);
      check(sched_ready && !mem_wr, "R8", "ready holds idle", {sched_ready, mem_wr}, 2'b10);
    end

    // R5 published 192-bit vector
    k192 = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
    model(k192, 2'd1); run(k192, 2'd1); check_run("R5", 2'd1);
    check({cap[24], cap[25]} == 128'he98ba06f448c773c8ecc720401002202, "R5",
          "last round key", {cap[24], cap[25]}, 128'he98ba06f448c773c8ecc720401002202);

    // R6 published 256-bit vector
    k256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    model(k256, 2'd2); run(k256, 2'd2); check_run("R6", 2'd2);
    check({cap[28], cap[29]} == 128'hfe4890d1e6188d0b046df344706c631e, "R6",
          "last round key", {cap[28], cap[29]}, 128'hfe4890d1e6188d0b046df344706c631e);

    // R7 junk in the unused low bits
    kr = {k128[255:128], {4{$urandom}}};
    model(k128, 2'd0); run(kr, 2'd0); check_run("R7", 2'd0);
    kr = {k192[255:64], {2{$urandom}}};
    model(k192, 2'd1); run(kr, 2'd1); check_run("R7", 2'd1);

    // R9 restart in the middle of an expansion
    pulse_start(k256, 2'd2);
    repeat (9) @(negedge clk);
    model(k192, 2'd1); run(k192, 2'd1); check_run("R9", 2'd1);
    pulse_start(k128, 2'd0);
    repeat (30) @(negedge clk);
    model(k256, 2'd2); run(k256, 2'd2); check_run("R9", 2'd2);

    // R2 random keys on every length
    for (int r = 0; r < 9; r++) begin
      logic [1:0] m;
      m  = 2'(r % 3);
      kr = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      model(kr, m); run(kr, m);
      check_run(m == 0 ? "R4" : m == 1 ? "R5" : "R6", m);
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule